// File: doc/BRIEF.md
# Sequential Saturating 64-by-32 Integer Divider

This unit divides a 64-bit dividend by a 32-bit divisor and returns a 32-bit quotient. The dividend is built from a high-word value and a low operand. The divisor is a separate operand. A one-cycle `start_i` launches a division. The unit raises `busy_o` while it iterates and gives a one-cycle `done_o` pulse when the result is ready. A mode input selects unsigned or two's-complement signed arithmetic.

The quotient must fit in 32 bits. When it does not, the unit saturates to a limit that depends on the mode and on the sign of the true quotient, and it raises an overflow flag. A zero divisor does not start an iteration. It raises a trap flag and leaves the previous quotient and overflow flag untouched. Internally, both operands are reduced to magnitudes. A restoring shift-subtract loop produces one quotient bit per cycle over the full 64-bit width. The sign is applied and the range is checked on the untruncated 64-bit quotient.

Top module: `sat_div64`

## Requirements
- R1: In unsigned mode (`signed_i`=0), the dividend is `{hi_i, lo_i}` (`hi_i` in bits 63:32). When the quotient is at most 0xFFFF_FFFF, `quot_o` is the truncated quotient, `ovf_o`=0 and `dz_o`=0.
- R2: In unsigned mode, a quotient above 0xFFFF_FFFF gives `quot_o`=0xFFFF_FFFF and `ovf_o`=1.
- R3: In signed mode (`signed_i`=1), the quotient is truncated toward zero. When it lies in [-2^31, 2^31-1], `quot_o` is its two's-complement value and `ovf_o`=0.
- R4: In signed mode, a quotient above 2^31-1 gives 0x7FFF_FFFF and a quotient below -2^31 gives 0x8000_0000. In both cases `ovf_o`=1.
- R5: In signed mode, a dividend of exactly -2^63 overflows for every nonzero divisor. The result is 0x7FFF_FFFF for a negative divisor and 0x8000_0000 for a positive one.
- R6: An accepted start with `dvs_i`=0 gives `done_o`=1 and `dz_o`=1 in the next cycle. `busy_o` stays 0, and `quot_o` and `ovf_o` keep their previous values.
- R7: An accepted start with a nonzero divisor raises `busy_o` from the next cycle. `done_o` is a single-cycle pulse 2*W+1 cycles after the accepting edge, and `busy_o` is 0 while `done_o` is 1.
- R8: `quot_o`, `ovf_o` and `dz_o` hold until the next accepted start. A nonzero-divisor start clears `dz_o` at once, and the other two change only at completion.
- R9: A `start_i` asserted while `busy_o`=1 is ignored. It does not change the result, the flags or the completion time, even when it carries a zero divisor.
- R10: During and after synchronous active-high reset, `busy_o`, `done_o`, `quot_o`, `ovf_o` and `dz_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Launch a division when idle |
| signed_i | input | 1 | 1 = signed mode, 0 = unsigned mode |
| hi_i | input | W | Dividend bits 2W-1:W |
| lo_i | input | W | Dividend bits W-1:0 |
| dvs_i | input | W | Divisor |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle completion pulse |
| quot_o | output | W | Saturated quotient |
| ovf_o | output | 1 | Quotient saturated |
| dz_o | output | 1 | Divide-by-zero trap |

## Verification
The bench uses the default width W=32. At this width the saturation limits are 0x7FFF_FFFF, 0x8000_0000 and 0xFFFF_FFFF, and the expected completion time is exactly 65 cycles. The bench models the reference in 64-bit native arithmetic. This makes the tight corners directly reachable: dividends of ±2^31 and -2^63, and divisors of -1, INT32_MIN and INT32_MAX. It can then tell an exact fit at -2^31 from an overflow at +2^31.

// File: rtl/sat_div_pkg.sv
package sat_div_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_WRAP = 2'd2
    } div_state_e;
endpackage

// File: rtl/sat_div_prep.sv
// Operand conditioning: forms the wide dividend and reduces both
// operands to magnitudes, plus the sign the final quotient must take.
module sat_div_prep #(
    parameter int unsigned W = 32
) (
    input  logic             signed_i,
    input  logic [W-1:0]     hi_i,
    input  logic [W-1:0]     lo_i,
    input  logic [W-1:0]     dvs_i,
    output logic [2*W-1:0]   dvd_mag_o,
    output logic [W-1:0]     dvs_mag_o,
    output logic             neg_o,
    output logic             dvs_zero_o
);
    localparam int unsigned DW = 2 * W;

    logic [DW-1:0] dvd_raw;
    logic          dvd_neg;
    logic          dvs_neg;

    always_comb begin
        dvd_raw    = {hi_i, lo_i};
        dvd_neg    = signed_i & hi_i[W-1];
        dvs_neg    = signed_i & dvs_i[W-1];
        // -2^63 maps to 2^63, which still fits the unsigned magnitude
        dvd_mag_o  = dvd_neg ? -dvd_raw : dvd_raw;
        dvs_mag_o  = dvs_neg ? -dvs_i : dvs_i;
        neg_o      = dvd_neg ^ dvs_neg;
        dvs_zero_o = (dvs_i == '0);
    end
endmodule

// File: rtl/sat_div_core.sv
// Restoring shift-subtract loop, one quotient bit per step.
module sat_div_core #(
    parameter int unsigned W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic             step_i,
    input  logic [2*W-1:0]   dvd_i,
    input  logic [W-1:0]     dvs_i,
    output logic [2*W-1:0]   quot_o
);
    localparam int unsigned DW = 2 * W;

    typedef struct packed {
        logic [W-1:0]  rem;
        logic [DW-1:0] acc;   // dividend bits shift out, quotient bits shift in
        logic [W-1:0]  dvs;
    } core_t;

    core_t        core_q, core_d;
    logic [W:0]   trial;
    logic [W+1:0] diff;

    always_comb begin
        core_d = core_q;
        trial  = {core_q.rem, core_q.acc[DW-1]};
        diff   = {1'b0, trial} - {2'b00, core_q.dvs};
        if (load_i) begin
            core_d.rem = '0;
            core_d.acc = dvd_i;
            core_d.dvs = dvs_i;
        end else if (step_i) begin
            if (!diff[W+1]) begin
                core_d.rem = diff[W-1:0];
                core_d.acc = {core_q.acc[DW-2:0], 1'b1};
            end else begin
                core_d.rem = trial[W-1:0];
                core_d.acc = {core_q.acc[DW-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) core_q <= '0;
        else     core_q <= core_d;
    end

    assign quot_o = core_q.acc;

    // R1: the partial remainder never reaches the divisor after a step
    a_r1_rem_below_divisor: assert property (@(posedge clk) disable iff (rst)
        (step_i && !load_i) |=> (core_q.rem < core_q.dvs));
endmodule

// File: rtl/sat_div_post.sv
// Applies the sign and range-checks the full-width quotient magnitude.
module sat_div_post #(
    parameter int unsigned W = 32
) (
    input  logic [2*W-1:0] mag_i,
    input  logic           signed_i,
    input  logic           neg_i,
    output logic [W-1:0]   quot_o,
    output logic           ovf_o
);
    localparam int unsigned DW = 2 * W;
    localparam logic [DW-1:0] LIM_POS = {{(W+1){1'b0}}, {(W-1){1'b1}}};
    localparam logic [DW-1:0] LIM_NEG = {{W{1'b0}}, 1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0]  SAT_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0]  SAT_MIN = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0] low;

    always_comb begin
        low = mag_i[W-1:0];
        if (!signed_i) begin
            ovf_o  = |mag_i[DW-1:W];
            quot_o = ovf_o ? '1 : low;
        end else if (neg_i) begin
            ovf_o  = (mag_i > LIM_NEG);
            quot_o = ovf_o ? SAT_MIN : -low;
        end else begin
            ovf_o  = (mag_i > LIM_POS);
            quot_o = ovf_o ? SAT_MAX : low;
        end
    end
endmodule

// File: rtl/sat_div64.sv
module sat_div64 #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic         signed_i,
    input  logic [W-1:0] hi_i,
    input  logic [W-1:0] lo_i,
    input  logic [W-1:0] dvs_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] quot_o,
    output logic         ovf_o,
    output logic         dz_o
);
    import sat_div_pkg::*;

    localparam int unsigned DW    = 2 * W;
    localparam int unsigned ITER  = DW;
    localparam int unsigned CNT_W = $clog2(ITER);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(ITER - 1);
    localparam logic [W-1:0] SAT_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] SAT_MIN = {1'b1, {(W-1){1'b0}}};

    typedef struct packed {
        div_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic             mode;
        logic             neg;
        logic             done;
        logic [W-1:0]     quot;
        logic             ovf;
        logic             dz;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic [DW-1:0] dvd_mag;
    logic [W-1:0]  dvs_mag;
    logic          neg_w;
    logic          dvs_zero;
    logic          load_w;
    logic          step_w;
    logic [DW-1:0] mag_w;
    logic [W-1:0]  post_quot;
    logic          post_ovf;

    sat_div_prep #(.W(W)) prep_i (
        .signed_i  (signed_i),
        .hi_i      (hi_i),
        .lo_i      (lo_i),
        .dvs_i     (dvs_i),
        .dvd_mag_o (dvd_mag),
        .dvs_mag_o (dvs_mag),
        .neg_o     (neg_w),
        .dvs_zero_o(dvs_zero)
    );

    sat_div_core #(.W(W)) core_i (
        .clk   (clk),
        .rst   (rst),
        .load_i(load_w),
        .step_i(step_w),
        .dvd_i (dvd_mag),
        .dvs_i (dvs_mag),
        .quot_o(mag_w)
    );

    sat_div_post #(.W(W)) post_i (
        .mag_i   (mag_w),
        .signed_i(ctl_q.mode),
        .neg_i   (ctl_q.neg),
        .quot_o  (post_quot),
        .ovf_o   (post_ovf)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        load_w     = 1'b0;
        step_w     = 1'b0;
        unique case (ctl_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    if (dvs_zero) begin
                        ctl_d.dz   = 1'b1;
                        ctl_d.done = 1'b1;
                    end else begin
                        load_w      = 1'b1;
                        ctl_d.dz    = 1'b0;
                        ctl_d.mode  = signed_i;
                        ctl_d.neg   = neg_w;
                        ctl_d.cnt   = '0;
                        ctl_d.state = ST_RUN;
                    end
                end
            end
            ST_RUN: begin
                step_w    = 1'b1;
                ctl_d.cnt = ctl_q.cnt + CNT_W'(1);
                if (ctl_q.cnt == LAST) ctl_d.state = ST_WRAP;
            end
            ST_WRAP: begin
                ctl_d.quot  = post_quot;
                ctl_d.ovf   = post_ovf;
                ctl_d.done  = 1'b1;
                ctl_d.state = ST_IDLE;
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '0;
        else     ctl_q <= ctl_d;
    end

    assign busy_o = (ctl_q.state != ST_IDLE);
    assign done_o = ctl_q.done;
    assign quot_o = ctl_q.quot;
    assign ovf_o  = ctl_q.ovf;
    assign dz_o   = ctl_q.dz;

    // R6: zero divisor traps next cycle without touching the result
    a_r6_zero_traps: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o && dvs_i == '0) |=> (done_o && dz_o && !busy_o));
    a_r6_zero_keeps_result: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o && dvs_i == '0) |=> ($stable(quot_o) && $stable(ovf_o)));
    // R7: done is a single pulse, seen only when idle
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    a_r7_idle_at_done: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);
    // R8: idle without a start leaves every result output alone
    a_r8_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i) |=> ($stable(quot_o) && $stable(ovf_o) && $stable(dz_o)));
    // R9: an iteration in progress cannot be cut short by a start
    a_r9_run_continues: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.state == ST_RUN) |=> busy_o);
    // R2: unsigned overflow saturates to all ones
    a_r2_unsigned_sat: assert property (@(posedge clk) disable iff (rst)
        (done_o && ovf_o && !dz_o && !ctl_q.mode) |-> (quot_o == '1));
    // R4: signed overflow saturates to one of the two signed limits
    a_r4_signed_sat: assert property (@(posedge clk) disable iff (rst)
        (done_o && ovf_o && !dz_o && ctl_q.mode) |-> (quot_o == SAT_MAX || quot_o == SAT_MIN));
endmodule

// File: tb/sat_div64_tb_top.sv
module sat_div64_tb_top;
    localparam int unsigned W = 32;
    localparam int LAT = 2 * W + 1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic         sgn = 1'b0;
    logic [W-1:0] hi = '0;
    logic [W-1:0] lo = '0;
    logic [W-1:0] dvs = '0;
    logic         busy_o, done_o, ovf_o, dz_o;
    logic [W-1:0] quot_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    sat_div64 #(.W(W)) dut_i (
        .clk(clk), .rst(rst), .start_i(start), .signed_i(sgn),
        .hi_i(hi), .lo_i(lo), .dvs_i(dvs),
        .busy_o(busy_o), .done_o(done_o), .quot_o(quot_o),
        .ovf_o(ovf_o), .dz_o(dz_o)
    );

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
            finish_run();
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Reference model computed straight from R1..R5
    function automatic void ref_div(input bit s, input logic [31:0] h, l, d,
                                    output logic [31:0] q, output bit v);
        logic [63:0] un, uq;
        longint sn, sd, sq;
        if (!s) begin
            un = {h, l};
            uq = un / {32'd0, d};
            v  = (uq > 64'h0000_0000_FFFF_FFFF);
            q  = v ? 32'hFFFF_FFFF : uq[31:0];
        end else begin
            sn = $signed({h, l});
            sd = longint'($signed(d));
            if ({h, l} == 64'h8000_0000_0000_0000) begin
                v = 1'b1;
                q = (sd < 0) ? 32'h7FFF_FFFF : 32'h8000_0000;
            end else begin
                sq = sn / sd;
                if (sq > 64'sd2147483647) begin
                    v = 1'b1; q = 32'h7FFF_FFFF;
                end else if (sq < -64'sd2147483648) begin
                    v = 1'b1; q = 32'h8000_0000;
                end else begin
                    v = 1'b0; q = sq[31:0];
                end
            end
        end
    endfunction

    task automatic do_div(input bit s, input logic [31:0] h, l, d,
                          output logic [31:0] q, output bit v, output bit z,
                          output int lat, output bit busy1);
        @(negedge clk);
        start = 1'b1; sgn = s; hi = h; lo = l; dvs = d;
        @(negedge clk);
        start = 1'b0;
        busy1 = busy_o;
        lat = 0;
        while (!done_o && lat < 300) begin
            @(negedge clk);
            lat++;
        end
        q = quot_o; v = ovf_o; z = dz_o;
    endtask

    task automatic div_check(input string req, input bit s,
                             input logic [31:0] h, l, d);
        logic [31:0] q, eq;
        bit v, ev, z, b1;
        int lat;
        ref_div(s, h, l, d, eq, ev);
        do_div(s, h, l, d, q, v, z, lat, b1);
        chk(req, "quotient", 64'(q), 64'(eq));
        chk(req, "overflow", 64'(v), 64'(ev));
        chk(req, "trap", 64'(z), 64'd0);
        chk("R7", "latency", 64'(lat), 64'(LAT));
        chk("R7", "busy after start", 64'(b1), 64'd1);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10", "busy in reset", 64'(busy_o), 64'd0);
        chk("R10", "done in reset", 64'(done_o), 64'd0);
        chk("R10", "quot in reset", 64'(quot_o), 64'd0);
        chk("R10", "flags in reset", 64'({ovf_o, dz_o}), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R10", "idle after reset", 64'({busy_o, done_o, ovf_o, dz_o}), 64'd0);
    endtask

    task automatic t_unsigned_fit();
        logic [31:0] d, h;
        div_check("R1", 1'b0, 32'd0, 32'd100, 32'd7);
        div_check("R1", 1'b0, 32'd1, 32'd0, 32'd2);
        div_check("R1", 1'b0, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        for (int i = 0; i < 12; i++) begin
            d = $urandom() | 32'd1;
            h = $urandom() % d;
            div_check("R1", 1'b0, h, $urandom(), d);
        end
    endtask

    task automatic t_unsigned_ovf();
        div_check("R2", 1'b0, 32'd5, 32'd0, 32'd5);
        div_check("R2", 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd1);
        for (int i = 0; i < 6; i++)
            div_check("R2", 1'b0, $urandom() | 32'h8000_0000, $urandom(), ($urandom() >> 4) | 32'd1);
    endtask

    task automatic t_signed_fit();
        logic [31:0] l, d;
        div_check("R3", 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFF9, 32'd2);
        div_check("R3", 1'b1, 32'd0, 32'd7, 32'hFFFF_FFFE);
        div_check("R3", 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFF9, 32'hFFFF_FFFE);
        div_check("R3", 1'b1, 32'hFFFF_FFFF, 32'h8000_0000, 32'd1);
        div_check("R3", 1'b1, 32'd0, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
        div_check("R3", 1'b1, 32'hFFFF_FFFF, 32'h8000_0000, 32'h8000_0000);
        for (int i = 0; i < 12; i++) begin
            l = $urandom();
            d = $urandom() | 32'd1;
            div_check("R3", 1'b1, {32{l[31]}}, l, d);
        end
    endtask

    task automatic t_signed_ovf();
        div_check("R4", 1'b1, 32'd0, 32'h8000_0000, 32'd1);
        div_check("R4", 1'b1, 32'hFFFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF);
        div_check("R4", 1'b1, 32'h0000_0001, 32'd0, 32'hFFFF_FFFF);
        div_check("R4", 1'b1, 32'h4000_0000, 32'd0, 32'h7FFF_FFFF);
        div_check("R4", 1'b1, 32'hC000_0000, 32'd0, 32'h8000_0000);
        for (int i = 0; i < 6; i++)
            div_check("R4", 1'b1, $urandom(), $urandom(), ($urandom() >> 8) | 32'd1);
    endtask

    task automatic t_min_dividend();
        div_check("R5", 1'b1, 32'h8000_0000, 32'd0, 32'd1);
        div_check("R5", 1'b1, 32'h8000_0000, 32'd0, 32'hFFFF_FFFF);
        div_check("R5", 1'b1, 32'h8000_0000, 32'd0, 32'h8000_0000);
        div_check("R5", 1'b1, 32'h8000_0000, 32'd0, 32'h7FFF_FFFF);
        div_check("R5", 1'b1, 32'h8000_0000, 32'd0, 32'd3);
    endtask

    task automatic t_zero_div();
        logic [31:0] q0, q;
        bit v0, z0, v, z, b1;
        int lat;
        do_div(1'b0, 32'd1, 32'd0, 32'd1, q0, v0, z0, lat, b1);  // leaves ovf=1
        do_div(1'b1, 32'd0, 32'd9, 32'd0, q, v, z, lat, b1);
        chk("R6", "trap flag", 64'(z), 64'd1);
        chk("R6", "trap latency", 64'(lat), 64'd0);
        chk("R6", "no busy on trap", 64'(b1), 64'd0);
        chk("R6", "quotient kept", 64'(q), 64'(q0));
        chk("R6", "overflow kept", 64'(v), 64'(v0));
        repeat (5) @(negedge clk);
        chk("R8", "trap held", 64'(dz_o), 64'd1);
        @(negedge clk);
        start = 1'b1; sgn = 1'b0; hi = 32'd0; lo = 32'd40; dvs = 32'd8;
        @(negedge clk);
        start = 1'b0;
        chk("R8", "trap cleared on start", 64'(dz_o), 64'd0);
        chk("R8", "quotient held during run", 64'(quot_o), 64'(q0));
        while (!done_o) @(negedge clk);
        chk("R8", "new quotient", 64'(quot_o), 64'd5);
    endtask

    task automatic t_hold();
        logic [31:0] q;
        bit v, z, b1;
        int lat;
        do_div(1'b1, 32'hFFFF_FFFF, 32'hFFFF_FF00, 32'd16, q, v, z, lat, b1);
        chk("R3", "negative quotient", 64'(q), 64'hFFFF_FFF0);
        @(negedge clk);
        chk("R7", "done single cycle", 64'(done_o), 64'd0);
        repeat (10) @(negedge clk);
        chk("R8", "quotient held idle", 64'(quot_o), 64'hFFFF_FFF0);
        chk("R8", "flags held idle", 64'({ovf_o, dz_o}), 64'd0);
    endtask

    task automatic t_busy_start();
        int lat;
        @(negedge clk);
        start = 1'b1; sgn = 1'b0; hi = 32'd0; lo = 32'd1000; dvs = 32'd10;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        repeat (10) begin @(negedge clk); lat++; end
        start = 1'b1; sgn = 1'b1; hi = 32'h7000_0000; lo = 32'd0; dvs = 32'd0;
        repeat (3) begin @(negedge clk); lat++; end
        start = 1'b0;
        chk("R9", "no trap from busy start", 64'(dz_o), 64'd0);
        while (!done_o && lat < 300) begin @(negedge clk); lat++; end
        chk("R9", "latency unchanged", 64'(lat), 64'(LAT));
        chk("R9", "quotient unchanged", 64'(quot_o), 64'd100);
        chk("R9", "flags unchanged", 64'({ovf_o, dz_o}), 64'd0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        t_reset();
        t_unsigned_fit();
        t_unsigned_ovf();
        t_signed_fit();
        t_signed_ovf();
        t_min_dividend();
        t_zero_div();
        t_hold();
        t_busy_start();
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule